// File: doc/BRIEF.md
# Arbitrated Banked Dual-Port RAM

This block is a synchronous memory with two independent ports, called left and right. Each port has its own enable, write enable, address, write data, registered read data and an active-low busy flag. Either port can read or write any word. The storage is split into eight equal banks. The upper three address bits of a port pick a bank, and the remaining bits pick the word inside it. Two ports that reach different words proceed together in the same cycle, even when both words are in one bank.

When both ports are enabled on the same effective address in one cycle, an arbiter lets one of them through. It pulls the busy flag of the other low in that same cycle. The stalled port keeps its request unchanged and completes it on the following cycle, so a collision never loses or mixes data. A half-size input clears the top address bit on both ports, which confines every access to the lower four banks.

The address width is a parameter. With 14 bits the block holds 16K bytes, and in half-size mode 8K bytes. The default of 11 bits keeps elaboration small and gives 2K words in 8 banks of 256.

Top module: `twin_port_ram`

## Requirements
- R1: While reset is held and in the first cycle after it, both read data outputs are 0, both busy flags are high, and no stall priority is pending.
- R2: A granted write stores its data at the effective address on the clock edge. A granted read (en=1, we=0, busy_n=1) shows the stored byte on that port's read data one clock edge later.
- R3: A port's read data output keeps its value in every cycle in which that port has no granted read.
- R4: When both ports are enabled on different effective addresses, both busy flags stay high and both accesses complete in that cycle, including when the two addresses share a bank.
- R5: A collision means both ports are enabled with equal effective addresses. If the right port was not stalled in the previous cycle, the left port wins, and right busy_n is 0 in that same cycle.
- R6: A busy flag is low only while its own port is enabled, and the two flags are never low together.
- R7: A port stalled in one cycle has priority in the next. If it holds its request, it is granted, and the other port is made busy if it requests the same effective address again.
- R8: A stalled write is not committed while stalled. A stalled read, once granted, returns data that includes the write the winning port made in the conflict.
- R9: When half_mode is 1, address bit ADDR_W-1 is treated as 0 on both ports, both for storage and for collision detection.
- R10: Address bits [ADDR_W-1:ADDR_W-3] select one of 8 banks, and the lower bits select the word. Addresses that differ only in the bank bits hold separate data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_mode | input | 1 | 1 clears the top address bit on both ports |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port registered read data |
| l_busy_n | output | 1 | Left port stalled, active low |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port registered read data |
| r_busy_n | output | 1 | Right port stalled, active low |

## Verification
The stall-resolution assertions assume that a port whose busy flag is low keeps its enable, address and the half_mode input unchanged into the next cycle. That is the handshake the block expects from its users. The random stimulus enforces it by freezing a stalled port's inputs for one cycle, and by toggling half_mode only when no stall is pending. Addresses are drawn mostly from a small pool, with and without the top bit set, so that collisions, repeated collisions and half-mode aliasing occur often.

// File: rtl/twin_port_ram_pkg.sv
package twin_port_ram_pkg;

    typedef struct packed {
        logic l_stall;
        logic r_stall;
    } arb_state_t;

    localparam int unsigned BANK_BITS = 3;

endpackage

// File: rtl/tpr_addr_map.sv
module tpr_addr_map #(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned BANK_BITS = 3
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        half_mode,
    output logic [ADDR_W-1:0]           eff_addr,
    output logic [(1<<BANK_BITS)-1:0]   bank_oh,
    output logic [BANK_BITS-1:0]        bank_idx,
    output logic [ADDR_W-BANK_BITS-1:0] word
);
    localparam int unsigned WORD_W = ADDR_W - BANK_BITS;

    always_comb begin
        eff_addr = addr;
        if (half_mode) begin
            eff_addr[ADDR_W-1] = 1'b0;
        end
        bank_idx = eff_addr[ADDR_W-1 -: BANK_BITS];
        word     = eff_addr[WORD_W-1:0];
        bank_oh  = '0;
        bank_oh[bank_idx] = 1'b1;
    end
endmodule

// File: rtl/tpr_arbiter.sv
module tpr_arbiter
    import twin_port_ram_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] l_eff,
    input  logic [ADDR_W-1:0] r_eff,
    output logic              l_grant,
    output logic              r_grant,
    output logic              l_busy_n,
    output logic              r_busy_n
);
    arb_state_t st_d, st_q;
    logic       collide;
    logic       l_lose;
    logic       r_lose;

    always_comb begin
        collide  = l_en && r_en && (l_eff == r_eff);
        // previously stalled side takes the tie; left by default
        l_lose   = collide && st_q.r_stall;
        r_lose   = collide && !st_q.r_stall;
        l_grant  = l_en && !l_lose;
        r_grant  = r_en && !r_lose;
        l_busy_n = !l_lose;
        r_busy_n = !r_lose;
        st_d.l_stall = l_lose;
        st_d.r_stall = r_lose;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tpr_bank.sv
module tpr_bank #(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [WORD_W-1:0] a_word,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic [WORD_W-1:0] b_word,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int unsigned DEPTH = 1 << WORD_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) begin
            mem[a_word] <= a_wdata;
        end
        if (b_we) begin
            mem[b_word] <= b_wdata;
        end
    end

    assign a_rdata = mem[a_word];
    assign b_rdata = mem[b_word];
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
    import twin_port_ram_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_mode,
    input  logic              l_en,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_busy_n,
    input  logic              r_en,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_busy_n
);
    localparam int unsigned NUM_BANKS = 1 << BANK_BITS;
    localparam int unsigned WORD_W    = ADDR_W - BANK_BITS;

    typedef struct packed {
        logic [DATA_W-1:0] l_rd;
        logic [DATA_W-1:0] r_rd;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [ADDR_W-1:0]    l_eff, r_eff;
    logic [NUM_BANKS-1:0] l_oh, r_oh;
    logic [BANK_BITS-1:0] l_idx, r_idx;
    logic [WORD_W-1:0]    l_word, r_word;
    logic                 l_grant, r_grant;
    logic [DATA_W-1:0]    l_bank_rd [NUM_BANKS];
    logic [DATA_W-1:0]    r_bank_rd [NUM_BANKS];

    tpr_addr_map #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS)) u_lmap (
        .addr(l_addr), .half_mode(half_mode), .eff_addr(l_eff),
        .bank_oh(l_oh), .bank_idx(l_idx), .word(l_word)
    );

    tpr_addr_map #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS)) u_rmap (
        .addr(r_addr), .half_mode(half_mode), .eff_addr(r_eff),
        .bank_oh(r_oh), .bank_idx(r_idx), .word(r_word)
    );

    tpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .r_en(r_en), .l_eff(l_eff), .r_eff(r_eff),
        .l_grant(l_grant), .r_grant(r_grant),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        tpr_bank #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_bank (
            .clk(clk),
            .a_we(l_grant && l_we && l_oh[b]),
            .a_word(l_word), .a_wdata(l_wdata), .a_rdata(l_bank_rd[b]),
            .b_we(r_grant && r_we && r_oh[b]),
            .b_word(r_word), .b_wdata(r_wdata), .b_rdata(r_bank_rd[b])
        );
    end

    always_comb begin
        st_d = st_q;
        if (l_grant && !l_we) begin
            st_d.l_rd = l_bank_rd[l_idx];
        end
        if (r_grant && !r_we) begin
            st_d.r_rd = r_bank_rd[r_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign l_rdata = st_q.l_rd;
    assign r_rdata = st_q.r_rd;
endmodule

// File: rtl/twin_port_ram_chk.sv
module twin_port_ram_chk #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              half_mode,
    input logic              l_en,
    input logic              l_we,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_busy_n,
    input logic              r_en,
    input logic              r_we,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_busy_n
);
    function automatic logic [ADDR_W-1:0] eff(input logic [ADDR_W-1:0] a, input logic h);
        logic [ADDR_W-1:0] e;
        e = a;
        if (h) e[ADDR_W-1] = 1'b0;
        return e;
    endfunction

    logic same_loc;
    assign same_loc = l_en && r_en && (eff(l_addr, half_mode) == eff(r_addr, half_mode));

    assert_busy_needs_en_l_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !l_en |-> l_busy_n);
    assert_busy_needs_en_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !r_en |-> r_busy_n);
    assert_never_both_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));
    assert_apart_no_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && r_en && !same_loc) |-> (l_busy_n && r_busy_n));
    assert_tie_one_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        same_loc |-> ($countones({~l_busy_n, ~r_busy_n}) == 1));
    assert_stall_clears_l_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !l_busy_n |=> (l_busy_n || !(l_en && $stable(l_addr) && $stable(half_mode))));
    assert_stall_clears_r_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !r_busy_n |=> (r_busy_n || !(r_en && $stable(r_addr) && $stable(half_mode))));
    assert_rdata_hold_l_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_en && !l_we && l_busy_n) |=> $stable(l_rdata));
    assert_rdata_hold_r_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_en && !r_we && r_busy_n) |=> $stable(r_rdata));
endmodule

bind twin_port_ram twin_port_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .half_mode(half_mode),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_rdata(l_rdata), .l_busy_n(l_busy_n),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_rdata(r_rdata), .r_busy_n(r_busy_n)
);

// File: tb/twin_port_ram_tb_top.sv
`timescale 1ns/1ps
module twin_port_ram_tb_top;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int TOP = 1 << (AW - 1);
    localparam int STRIDE = 1 << (AW - 3);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic half_mode = 1'b0;
    logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_busy_n, r_busy_n;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] mdl [1<<AW];
    logic [DW-1:0] exp_l = '0, exp_r = '0;
    logic m_l_stall = 0, m_r_stall = 0;

    always #2 clk = ~clk;

    twin_port_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .half_mode(half_mode),
        .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_busy_n(l_busy_n),
        .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_busy_n(r_busy_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] eff(input logic [AW-1:0] a);
        logic [AW-1:0] e;
        e = a;
        if (half_mode) e[AW-1] = 1'b0;
        return e;
    endfunction

    function automatic logic [DW-1:0] fill_val(input int i);
        return DW'(i ^ ((i >> 8) * 59));
    endfunction

    // one cycle: drive, check busy before the edge, update model, check read data after it
    task automatic step(input string tag,
                        input logic le, input logic lw, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                        input logic re, input logic rw, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
        logic coll, ll, rl;
        logic [AW-1:0] lea, rea;
        l_en = le; l_we = lw; l_addr = la; l_wdata = ld;
        r_en = re; r_we = rw; r_addr = ra; r_wdata = rd;
        #1;
        lea = eff(la);
        rea = eff(ra);
        coll = le && re && (lea == rea);
        rl = coll && !m_r_stall;
        ll = coll && m_r_stall;
        chk({tag, " left busy_n"}, 32'(l_busy_n), 32'(!ll));
        chk({tag, " right busy_n"}, 32'(r_busy_n), 32'(!rl));
        @(posedge clk);
        if (le && !ll && !lw) exp_l = mdl[lea];
        if (re && !rl && !rw) exp_r = mdl[rea];
        if (le && !ll && lw) mdl[lea] = ld;
        if (re && !rl && rw) mdl[rea] = rd;
        m_l_stall = ll;
        m_r_stall = rl;
        @(negedge clk);
        chk({tag, " left rdata"}, 32'(l_rdata), 32'(exp_l));
        chk({tag, " right rdata"}, 32'(r_rdata), 32'(exp_r));
    endtask

    function automatic logic [AW-1:0] pick_addr();
        logic [AW-1:0] a;
        if ($urandom % 4 == 0) a = AW'($urandom);
        else a = AW'(($urandom % 4) | (($urandom % 2) * TOP));
        return a;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic pl_en, pl_we, pr_en, pr_we;
        logic [AW-1:0] pl_a, pr_a;
        logic [DW-1:0] pl_d, pr_d;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset left rdata", 32'(l_rdata), 0);
        chk("R1 reset right busy_n", 32'(r_busy_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset right rdata", 32'(r_rdata), 0);
        chk("R1 after reset left busy_n", 32'(l_busy_n), 1);

        for (int i = 0; i < TOP; i++) begin
            step("R10 fill", 1, 1, AW'(i), fill_val(i), 1, 1, AW'(i + TOP), fill_val(i + TOP));
        end

        step("R10 bank split", 1, 0, 7, 0, 1, 0, AW'(7 + STRIDE), 0);
        step("R10 bank split", 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R10 distinct banks", 32'(l_rdata != r_rdata), 1);

        step("R4 same bank writes", 1, 1, 5, 8'h11, 1, 1, 6, 8'h22);
        step("R4 same bank reads", 1, 0, 6, 0, 1, 0, 5, 0);
        step("R4 idle", 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R4 left read", 32'(l_rdata), 32'h22);

        step("R5 left write wins", 1, 1, 9, 8'hAA, 1, 0, 9, 0);
        step("R8 stalled read", 0, 0, 0, 0, 1, 0, 9, 0);
        chk("R8 stalled read sees winner write", 32'(r_rdata), 32'hAA);

        step("R8 left read wins", 1, 0, 20, 0, 1, 1, 20, 8'h55);
        chk("R8 blocked write not committed", 32'(l_rdata), 32'(fill_val(20)));
        step("R8 held write", 0, 0, 0, 0, 1, 1, 20, 8'h55);
        step("R8 read back", 1, 0, 20, 0, 0, 0, 0, 0);
        chk("R8 write after grant", 32'(l_rdata), 32'h55);

        step("R7 first tie", 1, 1, 12, 8'h01, 1, 1, 12, 8'h02);
        step("R7 stalled right first", 1, 1, 12, 8'h03, 1, 1, 12, 8'h02);
        chk("R7 left now busy", 32'(m_l_stall), 1);
        step("R7 left completes", 1, 1, 12, 8'h03, 0, 0, 0, 0);
        step("R7 read back", 1, 0, 12, 0, 0, 0, 0, 0);
        chk("R7 final value", 32'(l_rdata), 32'h03);

        step("R6 idle left no busy", 0, 1, 30, 8'h09, 1, 1, 30, 8'h08);
        step("R6 read", 1, 0, 30, 0, 0, 0, 0, 0);
        chk("R6 write by right only", 32'(l_rdata), 32'h08);

        step("R3 write keeps rdata", 1, 1, 40, 8'h01, 0, 0, 0, 0);
        chk("R3 left rdata held", 32'(l_rdata), 32'h08);

        half_mode = 1'b1;
        step("R9 half write alias", 1, 1, AW'(TOP + 3), 8'h77, 0, 0, 0, 0);
        half_mode = 1'b0;
        step("R9 full read low", 1, 0, 3, 0, 1, 0, AW'(TOP + 3), 0);
        chk("R9 alias hit lower half", 32'(l_rdata), 32'h77);
        chk("R9 upper half untouched", 32'(r_rdata), 32'(fill_val(TOP + 3)));
        half_mode = 1'b1;
        step("R9 alias collision", 1, 0, 3, 0, 1, 1, AW'(TOP + 3), 8'h66);
        step("R9 alias held", 0, 0, 0, 0, 1, 1, AW'(TOP + 3), 8'h66);
        half_mode = 1'b0;

        pl_en = 0; pl_we = 0; pl_a = '0; pl_d = '0;
        pr_en = 0; pr_we = 0; pr_a = '0; pr_d = '0;
        for (int n = 0; n < 4000; n++) begin
            if (!m_l_stall) begin
                pl_en = ($urandom % 5) != 0; pl_we = 1'($urandom); pl_a = pick_addr(); pl_d = DW'($urandom);
            end
            if (!m_r_stall) begin
                pr_en = ($urandom % 5) != 0; pr_we = 1'($urandom); pr_a = pick_addr(); pr_d = DW'($urandom);
            end
            if (!m_l_stall && !m_r_stall && ($urandom % 150 == 0)) half_mode = ~half_mode;
            step("R2 random", pl_en, pl_we, pl_a, pl_d, pr_en, pr_we, pr_a, pr_d);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule